// File: doc/BRIEF.md
# Dual-Phase Board Energy Summer

This block forms the running energy sum of one front-end digitizer board. Each board carries sixteen converter channels that sample at twice the system clock, so every clock cycle delivers two 8-bit samples per channel: an earlier (even-phase) sample and a later (odd-phase) sample. The block feeds the two phases into two independent, fully pipelined binary adder trees. A new set of samples can be accepted on every clock, and each set produces a result after a fixed latency.

Two output formats are offered. In full-precision mode, both phase sums are presented side by side, which gives two 12-bit energies per clock. In reduced-precision mode, the two phases are averaged into a single 12-bit board sum, which halves the bandwidth needed downstream at the cost of time resolution. A valid flag follows each result through the pipeline. The active format changes only when no data is in flight, so every result leaves in one well-defined format.

Top module: `board_energy_sum`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its pipeline. After that edge, `out_valid` is 0, both sums are 0 and `out_mode` is 0 (full precision), whatever `in_valid` and `samples` were.
- R2: Channel c (0..15), phase p (0 = even/earlier, 1 = odd/later) is taken from `samples[(2*c+p)*8 +: 8]` as an unsigned value.
- R3: In full-precision mode (`out_mode` = 0), a valid result carries the sum of the 16 phase-0 samples on `sum_a` and the sum of the 16 phase-1 samples on `sum_b`.
- R4: A sample set presented with `in_valid` high at clock edge k appears with `out_valid` high right after edge k+3 (four edges including k). Back-to-back inputs give back-to-back results, and `out_valid` is high for exactly the cycles that match a valid input.
- R5: In reduced-precision mode (`out_mode` = 1), a valid result carries floor((phase-0 sum + phase-1 sum) / 2) on `sum_a`, and `sum_b` is 0.
- R6: All-255 inputs give 4080 on each phase sum, and 4080 as the reduced average, with no wrap.
- R7: Whenever `out_valid` is 0, `sum_a` and `sum_b` are both 0.
- R8: `out_mode` shows the active format. It takes the value of `mode_sel` only at a clock edge where `mode_sel` differs from it, `in_valid` is low, and no valid set is still inside the pipeline. Otherwise the request waits, and results already in flight keep the old format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, half the sampling rate |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `samples` as a set to be summed |
| mode_sel | input | 1 | Requested format: 0 full precision, 1 reduced precision |
| samples | input | 256 | Two 8-bit samples for each of the 16 channels (layout in R2) |
| out_valid | output | 1 | Result on the sum outputs is valid |
| out_mode | output | 1 | Active format of the result |
| sum_a | output | 12 | Phase-0 sum, or the averaged sum in reduced mode |
| sum_b | output | 12 | Phase-1 sum, or 0 in reduced mode |

## Verification
Every result is due four edges after the edge that took its inputs. `out_mode` reflects a switch right after the edge that made it. The bench drives inputs on the falling edge. It records each driven set's expected result in a small ring indexed by step number, and on each falling edge it compares the outputs with the entry made four steps earlier. A model of the drain rule, with the in-flight count taken from the same ring, decides which format each entry expects. This keeps stalled mode requests, drain timing and format aligned with the cycle they belong to.

// File: rtl/bsum_pkg.sv
// Shared definitions for the board energy summer.
// Assumes nothing beyond a single clock domain.
package bsum_pkg;

    // Output format of the summer
    typedef enum logic {
        MODE_FULL    = 1'b0,
        MODE_REDUCED = 1'b1
    } sum_mode_t;

endpackage

// File: rtl/bsum_tree.sv
// Pipelined binary adder tree.
// Adds N_IN unsigned inputs of IN_W bits into one OUT_W-bit sum, one
// register level per tree level, so the latency is $clog2(N_IN) edges and
// a new input vector can be accepted every clock.
// Assumes N_IN is a power of two, at least 2, and OUT_W wide enough for
// N_IN * (2**IN_W - 1).
module bsum_tree #(
    parameter int N_IN  = 16,
    parameter int IN_W  = 8,
    parameter int OUT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IN*IN_W-1:0]    in_vec,
    output logic [OUT_W-1:0]        sum_q
);

    // Leaves are the zero-extended inputs; internal nodes use heap numbering
    logic [OUT_W-1:0] leaf   [N_IN];
    logic [OUT_W-1:0] node_q [1:N_IN-1];

    genvar k;
    generate
        for (k = 0; k < N_IN; k++) begin : g_leaf
            // Widen each input to the sum width
            assign leaf[k] = OUT_W'(in_vec[k*IN_W +: IN_W]);
        end

        for (k = 1; k < N_IN; k++) begin : g_node
            if (2*k >= N_IN) begin : g_bottom
                // Bottom level: add two leaves
                always_ff @(posedge clk) begin
                    if (!rst_n) node_q[k] <= '0;
                    else        node_q[k] <= leaf[2*k-N_IN] + leaf[2*k+1-N_IN];
                end
            end else begin : g_inner
                // Upper level: add two registered children
                always_ff @(posedge clk) begin
                    if (!rst_n) node_q[k] <= '0;
                    else        node_q[k] <= node_q[2*k] + node_q[2*k+1];
                end
            end
        end
    endgenerate

    assign sum_q = node_q[1];

endmodule

// File: rtl/bsum_vpipe.sv
// Valid-flag delay line matching the adder tree latency.
// Also reports whether any valid set is still in flight.
// Assumes DEPTH >= 2.
module bsum_vpipe #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic out_valid,
    output logic busy
);

    logic [DEPTH-1:0] sh_q;

    // Shift the valid flag alongside the data
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[DEPTH-2:0], in_valid};
    end

    assign out_valid = sh_q[DEPTH-1];
    assign busy      = |sh_q;

endmodule

// File: rtl/bsum_mode_ctl.sv
// Output format controller.
// Takes a requested format and applies it only when the pipeline is empty
// and no new set is entering, so every result leaves in a single format.
// Assumes busy covers every pipeline stage that holds a valid set.
module bsum_mode_ctl
    import bsum_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_req,
    input  logic      in_valid,
    input  logic      busy,
    output sum_mode_t mode_q
);

    logic switch_ok;

    // A switch is allowed only with nothing in flight and nothing entering
    always_comb switch_ok = (sum_mode_t'(mode_req) != mode_q) && !in_valid && !busy;

    // Hold the active format; update it on an allowed switch
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= MODE_FULL;
        else if (switch_ok) mode_q <= sum_mode_t'(mode_req);
    end

endmodule

// File: rtl/board_energy_sum.sv
// Board energy summer: two phase trees, valid tracking and format select.
// Splits the interleaved sample word into even and odd phases, sums each
// phase in its own pipelined tree, and formats the result according to the
// active mode. Results are zero while out_valid is low.
// Assumes NUM_CH is a power of two and SUM_W holds NUM_CH * (2**SAMPLE_W - 1).
module board_energy_sum
    import bsum_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int SAMPLE_W = 8,
    parameter int SUM_W    = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         mode_sel,
    input  logic [NUM_CH*2*SAMPLE_W-1:0] samples,
    output logic                         out_valid,
    output logic                         out_mode,
    output logic [SUM_W-1:0]             sum_a,
    output logic [SUM_W-1:0]             sum_b
);

    localparam int LAT   = $clog2(NUM_CH);
    localparam int PH_W  = NUM_CH*SAMPLE_W;

    logic [PH_W-1:0]  even_vec;
    logic [PH_W-1:0]  odd_vec;
    logic [SUM_W-1:0] even_sum;
    logic [SUM_W-1:0] odd_sum;
    logic [SUM_W:0]   both_sum;
    logic             pipe_valid;
    logic             pipe_busy;
    sum_mode_t        act_mode;

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_split
            // Phase 0 is the lower sample of each channel pair
            assign even_vec[c*SAMPLE_W +: SAMPLE_W] = samples[(2*c)*SAMPLE_W   +: SAMPLE_W];
            assign odd_vec [c*SAMPLE_W +: SAMPLE_W] = samples[(2*c+1)*SAMPLE_W +: SAMPLE_W];
        end
    endgenerate

    bsum_tree #(.N_IN(NUM_CH), .IN_W(SAMPLE_W), .OUT_W(SUM_W)) u_even_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vec (even_vec),
        .sum_q  (even_sum)
    );

    bsum_tree #(.N_IN(NUM_CH), .IN_W(SAMPLE_W), .OUT_W(SUM_W)) u_odd_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vec (odd_vec),
        .sum_q  (odd_sum)
    );

    bsum_vpipe #(.DEPTH(LAT)) u_vpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_valid (pipe_valid),
        .busy      (pipe_busy)
    );

    bsum_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (mode_sel),
        .in_valid (in_valid),
        .busy     (pipe_busy),
        .mode_q   (act_mode)
    );

    // Format the tree outputs for the active mode, blank when not valid
    always_comb begin
        both_sum = {1'b0, even_sum} + {1'b0, odd_sum};
        sum_a    = '0;
        sum_b    = '0;
        if (pipe_valid) begin
            if (act_mode == MODE_FULL) begin
                sum_a = even_sum;
                sum_b = odd_sum;
            end else begin
                sum_a = both_sum[SUM_W:1];
            end
        end
    end

    assign out_valid = pipe_valid;
    assign out_mode  = act_mode;

endmodule

// File: rtl/bsum_chk.sv
// Property checker for the board energy summer, bound to the top module.
// Tracks input valids independently to check the result timing.
module bsum_chk #(
    parameter int NUM_CH   = 16,
    parameter int SAMPLE_W = 8,
    parameter int SUM_W    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode_sel,
    input logic             out_valid,
    input logic             out_mode,
    input logic [SUM_W-1:0] sum_a,
    input logic [SUM_W-1:0] sum_b
);

    localparam int LAT     = $clog2(NUM_CH);
    localparam int MAX_SUM = NUM_CH * ((1 << SAMPLE_W) - 1);

    logic [LAT-1:0] trk_q;

    // Independent record of recent input valids
    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= {trk_q[LAT-2:0], in_valid};
    end

    // R4
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == trk_q[LAT-1]);

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (sum_a == '0 && sum_b == '0));

    // R5
    reduced_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode) |-> (sum_b == '0));

    // R6
    sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (32'(sum_a) <= MAX_SUM && 32'(sum_b) <= MAX_SUM));

    // R8
    mode_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode != $past(out_mode)) |-> (!$past(in_valid) && !out_valid));

    // R8
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode != $past(out_mode)) |-> (out_mode == $past(mode_sel)));

endmodule

bind board_energy_sum bsum_chk #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .SUM_W    (SUM_W)
) u_bsum_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode_sel  (mode_sel),
    .out_valid (out_valid),
    .out_mode  (out_mode),
    .sum_a     (sum_a),
    .sum_b     (sum_b)
);

// File: tb/tb_board_energy_sum.sv
// Self-checking bench: sweeps, walking samples, random sets and mode drains.
module tb_board_energy_sum;

    localparam int CLK_PERIOD = 8;
    localparam int NCH        = 16;
    localparam int SW         = 8;
    localparam int IW         = NCH*2*SW;
    localparam int WD_CYCLES  = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          mode_sel = 1'b0;
    logic [IW-1:0] samples = '0;
    logic          out_valid;
    logic          out_mode;
    logic [11:0]   sum_a;
    logic [11:0]   sum_b;

    int nchk = 0;
    int nfail = 0;
    int n = 0;
    int act = 0;
    bit done = 0;

    // Ring of expected results indexed by step number
    int    rv [8];
    int    ra [8];
    int    rb [8];
    string rt [8];

    board_energy_sum dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode_sel  (mode_sel),
        .samples   (samples),
        .out_valid (out_valid),
        .out_mode  (out_mode),
        .sum_a     (sum_a),
        .sum_b     (sum_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int phase_sum(input logic [IW-1:0] s, input int p);
        int t = 0;
        for (int c = 0; c < NCH; c++) t += int'(s[(2*c+p)*SW +: SW]);
        return t;
    endfunction

    // One clock step: check the result due now, then drive the next set
    task automatic step(input logic v, input logic m, input logic [IW-1:0] s, input string tag);
        int  idx;
        int  e;
        int  o;
        bit  busy;
        @(negedge clk);
        idx = (n + 4) & 7;
        chk("R4 out_valid", int'(out_valid), rv[idx]);
        chk({rt[idx], " sum_a"}, int'(sum_a), ra[idx]);
        chk({rt[idx], " sum_b"}, int'(sum_b), rb[idx]);
        chk("R8 out_mode", int'(out_mode), act);
        busy = (rv[(n+7)&7] != 0) || (rv[(n+6)&7] != 0) || (rv[(n+5)&7] != 0) || (rv[(n+4)&7] != 0);
        if (int'(m) != act && !v && !busy) act = int'(m);
        in_valid = v;
        mode_sel = m;
        samples  = s;
        e = phase_sum(s, 0);
        o = phase_sum(s, 1);
        idx = n & 7;
        rv[idx] = int'(v);
        if (!v) begin
            ra[idx] = 0; rb[idx] = 0; rt[idx] = "R7";
        end else if (act == 0) begin
            ra[idx] = e; rb[idx] = o; rt[idx] = tag;
        end else begin
            ra[idx] = (e + o) >> 1; rb[idx] = 0; rt[idx] = tag;
        end
        n++;
    endtask

    function automatic logic [IW-1:0] fill(input int v0, input int v1);
        logic [IW-1:0] s = '0;
        for (int c = 0; c < NCH; c++) begin
            s[(2*c)*SW +: SW]   = SW'(v0);
            s[(2*c+1)*SW +: SW] = SW'(v1);
        end
        return s;
    endfunction

    function automatic logic [IW-1:0] rnd_set();
        logic [IW-1:0] s;
        for (int w = 0; w < IW/32; w++) s[w*32 +: 32] = $urandom;
        return s;
    endfunction

    initial begin
        logic [IW-1:0] s;
        for (int i = 0; i < 8; i++) begin
            rv[i] = 0; ra[i] = 0; rb[i] = 0; rt[i] = "R7";
        end
        // R1: reset with live-looking inputs
        in_valid = 1'b1;
        mode_sel = 1'b1;
        samples  = fill(255, 255);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 sum_a", int'(sum_a), 0);
        chk("R1 sum_b", int'(sum_b), 0);
        chk("R1 out_mode", int'(out_mode), 0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        mode_sel = 1'b0;

        // R3: sweep all sample values, opposite levels on the two phases
        for (int v = 0; v < 256; v++) step(1'b1, 1'b0, fill(v, 255 - v), "R3");
        // R6: full-scale input in full mode
        step(1'b1, 1'b0, fill(255, 255), "R6");
        step(1'b1, 1'b0, fill(255, 0), "R6");
        // R2: one non-zero sample walking over every channel and phase
        for (int c = 0; c < NCH; c++) begin
            for (int p = 0; p < 2; p++) begin
                s = '0;
                s[(2*c+p)*SW +: SW] = SW'(11 + 9*c + 101*p);
                step(1'b1, 1'b0, s, "R2");
            end
        end
        // R4: random sets with gaps
        for (int i = 0; i < 60; i++) step(($urandom % 4) != 0, 1'b0, rnd_set(), "R4");
        // R8: request reduced mode while streaming; it must wait
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, rnd_set(), "R8");
        for (int i = 0; i < 8; i++)  step(1'b0, 1'b1, rnd_set(), "R8");
        // R5: reduced mode sweep and random sets
        for (int v = 0; v < 256; v++) step(1'b1, 1'b1, fill(v, (v * 7) & 255), "R5");
        for (int i = 0; i < 60; i++)  step(($urandom % 3) != 0, 1'b1, rnd_set(), "R5");
        s = '0;
        s[7:0] = 8'd1;
        step(1'b1, 1'b1, s, "R5");
        // R6: full-scale input in reduced mode
        step(1'b1, 1'b1, fill(255, 255), "R6");
        // R8: back to full mode after a drain, with a stalled request first
        step(1'b1, 1'b0, rnd_set(), "R8");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0, "R8");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, rnd_set(), "R3");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0, "R7");
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL R4 watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule